// File: doc/BRIEF.md
# Asynchronous Serial Port Register Interface

This block is the processor-facing side of a byte-oriented asynchronous serial port. It has two byte-wide locations: a control/status location and a data location. The line side is abstracted to byte strobes. A received byte arrives with a one-cycle strobe. An outgoing byte is offered with a valid/ready pair and is released only while the clear-to-send input is asserted. The carrier-detect and clear-to-send inputs are active low.

A lost carrier is caught in a sticky latch. While the latch is set, the carrier bit in the status register is frozen at "inactive" and a receive-side interrupt may be raised. Software releases the latch by reading the data location. Interrupt requests reach the system as a one-cycle pulse on the line chosen by a programmable vector number. A programmable byte goes with each pulse, for the system to place on its data bus. Requests pass only while a global enable input is high.

Top module: `serial_port_regs`

## Requirements
- R1: While reset is held and just after it, the status byte reads 0x0C: only bit 3 (clear-to-send, 1 = inactive) and bit 2 (carrier, 1 = inactive) are set. `rts_n` is 1, `tx_valid` is 0 and no interrupt line is high.
- R2: A control write with bits [1:0] = 2'b11 is a master reset. It clears every status bit except bits 2 and 3, zeroes the receive buffer and the transmit-pending flag, clears both interrupt enables and the carrier latch, and drives `rts_n` to 1.
- R3: Any other control write sets the receive interrupt enable from bit 7. It sets the transmit interrupt enable only when bits [6:5] = 2'b01. It drives `rts_n` to 1 only when bits [6:5] = 2'b10, and to 0 otherwise.
- R4: While the carrier latch is clear, status bit 2 takes the value of `dcd_n` one clock later.
- R5: When status bit 2 is 0 and `dcd_n` is 1 with the latch clear, the latch sets and bit 2 becomes 1. A receive interrupt is requested if enabled. Bit 2 then stays 1 until a data read releases the latch.
- R6: A data read returns the receive buffer. It clears RDRF (bit 0), OVRN (bit 4), FE (bit 5), PE (bit 6) and IRQ (bit 7), and clears the carrier latch. No error source exists on the byte-level line side, so bits 4 to 6 always read 0.
- R7: A data write loads the transmit buffer, clears TDRE (bit 1) and IRQ (bit 7), and sets transmit pending.
- R8: `tx_valid` is high only while a byte is pending and status bit 3 is 0; `tx_byte` is the last written byte. When `tx_valid` and `tx_ready` are both high, pending clears and TDRE sets. A transmit interrupt is requested if it is enabled.
- R9: A `rx_strobe` while status bit 2 is 0 stores `rx_byte`, sets RDRF and requests a receive interrupt if it is enabled. A strobe while bit 2 is 1 changes nothing.
- R10: A request takes effect only when `glob_int_en` is high. It then sets status bit 7, pulses `int_lines[vec_sel]` for one cycle and loads `int_data` with `vec_byte`, all one clock after the event.
- R11: Status bit 3 takes the value of `cts_n` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control/status, 1 = data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (status or receive buffer) |
| rx_strobe | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte offered to the line |
| tx_ready | input | 1 | Line accepts the offered byte |
| tx_byte | output | 8 | Transmit buffer |
| dcd_n | input | 1 | Carrier detect, active low |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |
| glob_int_en | input | 1 | Global vectored interrupt enable |
| vec_sel | input | 3 | Programmed vector number |
| vec_byte | input | 8 | Programmed data-bus byte |
| int_lines | output | 8 | One-cycle request pulse per vector |
| int_data | output | 8 | Data-bus byte for the last request |

## Verification
Some properties are checked on every clock by the assertions. These are the frozen carrier bit while the latch is set, and the latch setting on carrier loss. They also cover clear-to-send tracking, pending set by a write and cleared by a handoff, and the ignoring of receive strobes without carrier. The last group is the master-reset outcome for the enables and `rts_n`, together with the one-hot, gated interrupt lines. Only the bench scenarios can show the byte-level results through the bus. These are the exact status values after each event, the receive and transmit data through the scoreboard, and the release of the latch by a data read. They also include interrupts that stay silent with the global enable low or after a master reset.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
  localparam int BYTE_W = 8;

  localparam int ST_RDRF = 0;
  localparam int ST_TDRE = 1;
  localparam int ST_DCD  = 2;
  localparam int ST_CTS  = 3;
  localparam int ST_IRQ  = 7;

  localparam int CT_RIE = 7;

  function automatic logic ctl_is_mreset(input logic [BYTE_W-1:0] c);
    return c[1:0] == 2'b11;
  endfunction

  function automatic logic ctl_tx_int(input logic [BYTE_W-1:0] c);
    return c[6:5] == 2'b01;
  endfunction

  function automatic logic ctl_rts_off(input logic [BYTE_W-1:0] c);
    return c[6:5] == 2'b10;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_status(
    input logic rdrf, input logic tdre, input logic dcd,
    input logic cts,  input logic irq);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[ST_RDRF] = rdrf;
    s[ST_TDRE] = tdre;
    s[ST_DCD]  = dcd;
    s[ST_CTS]  = cts;
    s[ST_IRQ]  = irq;
    return s;
  endfunction
endpackage

// File: rtl/serial_port_ctrl.sv
module serial_port_ctrl
  import serial_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [BYTE_W-1:0] ctl_data,
  output logic              mreset,
  output logic              rx_int_en,
  output logic              tx_int_en,
  output logic              rts_n
);
  assign mreset = ctl_wr && ctl_is_mreset(ctl_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_int_en <= 1'b0;
      tx_int_en <= 1'b0;
      rts_n     <= 1'b1;
    end else if (mreset) begin
      rx_int_en <= 1'b0;
      tx_int_en <= 1'b0;
      rts_n     <= 1'b1;
    end else if (ctl_wr) begin
      rx_int_en <= ctl_data[CT_RIE];
      tx_int_en <= ctl_tx_int(ctl_data);
      rts_n     <= ctl_rts_off(ctl_data);
    end
  end

  // R2: master reset leaves enables off and RTS inactive
  a_r2_mreset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mreset |=> (!rx_int_en && !tx_int_en && rts_n));
endmodule

// File: rtl/serial_port_modem.sv
module serial_port_modem (
  input  logic clk,
  input  logic rst_n,
  input  logic dcd_n,
  input  logic cts_n,
  input  logic data_rd,
  input  logic mreset,
  output logic dcd_st,
  output logic cts_st,
  output logic ev_carrier_lost
);
  logic loss_latch;

  assign ev_carrier_lost = !loss_latch && !dcd_st && dcd_n && !mreset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcd_st     <= 1'b1;
      cts_st     <= 1'b1;
      loss_latch <= 1'b0;
    end else begin
      cts_st <= cts_n;
      if (!loss_latch) dcd_st <= dcd_n;
      if (mreset)               loss_latch <= 1'b0;
      else if (ev_carrier_lost) loss_latch <= 1'b1;
      else if (data_rd)         loss_latch <= 1'b0;
    end
  end

  // R5: carrier bit frozen inactive while latched
  a_r5_dcd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    loss_latch |=> dcd_st);
  // R5: carrier loss sets the latch
  a_r5_loss_latches: assert property (@(posedge clk) disable iff (!rst_n)
    ev_carrier_lost |=> (loss_latch && dcd_st));
  // R11: clear-to-send bit tracks the pin
  a_r11_cts_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cts_st == $past(cts_n)));
endmodule

// File: rtl/serial_port_irq.sv
module serial_port_irq
  import serial_port_pkg::*;
#(
  parameter int NVEC = 8,
  localparam int VW  = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_req,
  input  logic              glob_int_en,
  input  logic [VW-1:0]     vec_sel,
  input  logic [BYTE_W-1:0] vec_byte,
  output logic              ev_fire,
  output logic [NVEC-1:0]   int_lines,
  output logic [BYTE_W-1:0] int_data
);
  assign ev_fire = ev_req && glob_int_en;

  for (genvar v = 0; v < NVEC; v++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) int_lines[v] <= 1'b0;
      else        int_lines[v] <= ev_fire && (vec_sel == VW'(v));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       int_data <= '0;
    else if (ev_fire) int_data <= vec_byte;
  end

  // R10: at most one line pulses
  a_r10_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(int_lines));
  // R10: nothing pulses without the global enable
  a_r10_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_int_en |=> (int_lines == '0));
endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
  import serial_port_pkg::*;
#(
  parameter int NVEC = 8,
  localparam int VW  = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              rx_strobe,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              dcd_n,
  input  logic              cts_n,
  output logic              rts_n,
  input  logic              glob_int_en,
  input  logic [VW-1:0]     vec_sel,
  input  logic [BYTE_W-1:0] vec_byte,
  output logic [NVEC-1:0]   int_lines,
  output logic [BYTE_W-1:0] int_data
);
  logic ctl_wr, data_wr, data_rd, mreset;
  logic rx_int_en, tx_int_en;
  logic dcd_st, cts_st;
  logic ev_carrier_lost, ev_rx_take, ev_tx_done, ev_req, ev_fire;
  logic rdrf, tdre, irq_st, pending;
  logic [BYTE_W-1:0] rx_buf, tx_buf;

  assign ctl_wr  = bus_sel &&  bus_wr && !bus_addr;
  assign data_wr = bus_sel &&  bus_wr &&  bus_addr;
  assign data_rd = bus_sel && !bus_wr &&  bus_addr;

  serial_port_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(bus_wdata),
    .mreset(mreset), .rx_int_en(rx_int_en), .tx_int_en(tx_int_en),
    .rts_n(rts_n));

  serial_port_modem u_modem (
    .clk(clk), .rst_n(rst_n), .dcd_n(dcd_n), .cts_n(cts_n),
    .data_rd(data_rd), .mreset(mreset), .dcd_st(dcd_st), .cts_st(cts_st),
    .ev_carrier_lost(ev_carrier_lost));

  assign tx_valid   = pending && !cts_st;
  assign tx_byte    = tx_buf;
  assign ev_tx_done = tx_valid && tx_ready && !mreset;
  assign ev_rx_take = rx_strobe && !dcd_st && !mreset;
  assign ev_req     = (rx_int_en && (ev_rx_take || ev_carrier_lost)) ||
                      (tx_int_en && ev_tx_done && !data_wr);

  serial_port_irq #(.NVEC(NVEC)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev_req(ev_req), .glob_int_en(glob_int_en),
    .vec_sel(vec_sel), .vec_byte(vec_byte), .ev_fire(ev_fire),
    .int_lines(int_lines), .int_data(int_data));

  always_ff @(posedge clk) begin
    if (!rst_n || mreset) begin
      rdrf    <= 1'b0;
      tdre    <= 1'b0;
      irq_st  <= 1'b0;
      pending <= 1'b0;
      rx_buf  <= '0;
    end else begin
      if (ev_rx_take)   rdrf <= 1'b1;
      else if (data_rd) rdrf <= 1'b0;
      if (data_wr)         tdre <= 1'b0;
      else if (ev_tx_done) tdre <= 1'b1;
      if (data_wr)         pending <= 1'b1;
      else if (ev_tx_done) pending <= 1'b0;
      if (ev_fire)                  irq_st <= 1'b1;
      else if (data_rd || data_wr)  irq_st <= 1'b0;
      if (ev_rx_take) rx_buf <= rx_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       tx_buf <= '0;
    else if (data_wr) tx_buf <= bus_wdata;
  end

  assign bus_rdata = bus_addr ? rx_buf
                              : pack_status(rdrf, tdre, dcd_st, cts_st, irq_st);

  // R7: a data write leaves a byte pending
  a_r7_write_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !mreset) |=> (pending && !tdre));
  // R8: a completed handoff empties the buffer
  a_r8_handoff_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_done && !data_wr) |=> (!pending && tdre && !tx_valid));
  // R9: without carrier a strobe leaves the buffer alone
  a_r9_no_carrier_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe && dcd_st && !mreset) |=> $stable(rx_buf));
endmodule

// File: tb/tb_serial_port_regs.sv
module tb_serial_port_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  typedef struct { logic [7:0] v; string tag; } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic rx_strobe = 0, tx_valid, tx_ready = 0;
  logic [7:0] rx_byte = 0, tx_byte;
  logic dcd_n = 1, cts_n = 1, rts_n, glob_int_en = 0;
  logic [2:0] vec_sel = 0;
  logic [7:0] vec_byte = 0, int_data;
  logic [NV-1:0] int_lines, seen;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  exp_t rdq[$];
  exp_t txq[$];

  serial_port_regs #(.NVEC(NV)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_strobe(rx_strobe), .rx_byte(rx_byte), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_byte(tx_byte), .dcd_n(dcd_n), .cts_n(cts_n),
    .rts_n(rts_n), .glob_int_en(glob_int_en), .vec_sel(vec_sel),
    .vec_byte(vec_byte), .int_lines(int_lines), .int_data(int_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) seen <= seen | int_lines;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read and transmit items as the design produces them
  always @(posedge clk) begin
    if (rst_n && bus_sel && !bus_wr) begin
      exp_t e;
      if (rdq.size() == 0) chk(8'hEE, 8'h00, "read without expectation");
      else begin e = rdq.pop_front(); chk(bus_rdata, e.v, e.tag); end
    end
    if (rst_n && tx_valid && tx_ready) begin
      exp_t e;
      if (txq.size() == 0) chk(tx_byte, 8'h00, "R8 unexpected handoff");
      else begin e = txq.pop_front(); chk(tx_byte, e.v, e.tag); end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    exp_t e;
    e.v = exp; e.tag = tag; rdq.push_back(e);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rx(input logic [7:0] b);
    rx_strobe = 1; rx_byte = b;
    @(negedge clk);
    rx_strobe = 0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    seen = '0;
    idle(3);
    bus_addr = 0;
    #1;
    chk(bus_rdata, 8'h0C, "R1 status in reset");
    chk({7'b0, rts_n}, 8'h01, "R1 rts_n in reset");
    chk({7'b0, tx_valid}, 8'h00, "R1 tx_valid in reset");
    chk(int_lines, 8'h00, "R1 int lines in reset");
    dcd_n = 0; cts_n = 0;
    glob_int_en = 1; vec_sel = 3'd5; vec_byte = 8'hE7;
    @(negedge clk); rst_n = 1;
    idle(2);
    rd(0, 8'h00, "R4 R11 status follows active modem pins");

    // receive with interrupt
    wr(0, 8'h80);
    chk({7'b0, rts_n}, 8'h00, "R3 rts_n active for field 00");
    seen = '0;
    rx(8'h5A);
    rd(0, 8'h81, "R9 R10 status after receive");
    chk(seen, 8'h20, "R10 vector line 5 pulsed");
    chk(int_data, 8'hE7, "R10 data-bus byte");
    rd(1, 8'h5A, "R6 data read returns byte");
    rd(0, 8'h00, "R6 read clears RDRF and IRQ");

    // carrier loss
    seen = '0;
    dcd_n = 1;
    idle(1);
    dcd_n = 0;
    idle(2);
    rd(0, 8'h84, "R5 latched carrier and interrupt");
    chk(seen, 8'h20, "R5 carrier loss interrupt");
    rx(8'h33);
    rd(0, 8'h84, "R9 strobe without carrier ignored");
    rd(1, 8'h5A, "R9 buffer kept without carrier");
    idle(2);
    rd(0, 8'h00, "R5 R6 latch released by data read");

    // transmit gated by clear-to-send
    wr(0, 8'h20);
    cts_n = 1;
    idle(2);
    wr(1, 8'hC3);
    idle(1);
    chk({7'b0, tx_valid}, 8'h00, "R8 blocked while CTS inactive");
    rd(0, 8'h08, "R7 R11 TDRE cleared, CTS inactive");
    begin exp_t e; e.v = 8'hC3; e.tag = "R8 transmitted byte"; txq.push_back(e); end
    seen = '0;
    tx_ready = 1;
    cts_n = 0;
    idle(3);
    tx_ready = 0;
    chk({7'b0, tx_valid}, 8'h00, "R8 pending cleared after handoff");
    rd(0, 8'h82, "R8 TDRE and transmit interrupt");
    chk(seen, 8'h20, "R3 R8 transmit interrupt for field 01");

    // global enable low
    rd(1, 8'h5A, "R6 read to clear IRQ");
    rd(0, 8'h02, "R6 IRQ cleared");
    glob_int_en = 0;
    wr(0, 8'h80);
    seen = '0;
    rx(8'h11);
    rd(0, 8'h03, "R10 no IRQ bit without global enable");
    chk(seen, 8'h00, "R10 no line without global enable");
    wr(0, 8'h40);
    chk({7'b0, rts_n}, 8'h01, "R3 rts_n inactive for field 10");

    // master reset
    cts_n = 1;
    idle(2);
    wr(1, 8'h77);
    rd(0, 8'h09, "R7 pending byte before master reset");
    wr(0, 8'h80);
    wr(0, 8'h03);
    rd(0, 8'h08, "R2 only modem bits survive");
    chk({7'b0, rts_n}, 8'h01, "R2 rts_n inactive");
    rd(1, 8'h00, "R2 receive buffer zeroed");
    cts_n = 0;
    idle(3);
    chk({7'b0, tx_valid}, 8'h00, "R2 pending dropped");
    glob_int_en = 1;
    seen = '0;
    rx(8'h22);
    rd(0, 8'h01, "R2 receive interrupt disabled");
    chk(seen, 8'h00, "R2 no interrupt after master reset");
    rd(1, 8'h22, "R9 byte stored after master reset");

    idle(2);
    chk(8'(rdq.size() + txq.size()), 8'h00, "R8 scoreboard drained");
    done = 1;
    summary();
  end
endmodule